// File: doc/BRIEF.md
# Scaled-Counter Four-Channel PWM

This block is a pulse-width modulator with one free-running counter that serves four compare channels. A selectable number of low counter bits is dropped before the count reaches the comparators. A 16-bit window of the counter, moved up by a 4-bit scale setting, is therefore compared against each channel's threshold, and the scale setting fixes the period as 2^(16+scale) clock cycles. Each output pin is active-low. It is driven low while the scaled count is below the channel's threshold. Because of this, a threshold of zero turns the channel off, and a full-period low time cannot be reached.

Software drives the block through a plain word-wide register bus with one-cycle access. The bus holds a configuration word, the raw counter (readable and writable), the current scaled count (read-only) and the four thresholds. When the optional restart mode is on, channel 0's threshold becomes the period length: the counter goes back to zero right after the scaled count reaches it. New thresholds act on the very next comparison and are not delayed to a period boundary.

Top module: `scaled_pwm_top`

## Requirements
- R1: After reset every register reads zero, the counter is stopped and all four outputs are high (pwmOutN = 4'hF).
- R2: The configuration word at offset 0x00 keeps only bits 3:0 (scale), 8, 9 (restart), 10, 12 (run), 13, 16, 24 and 28, and reads every other bit as zero. Threshold i sits at offset 0x20 + 4*i and keeps the low 16 bits of the written word.
- R3: While run (bit 12) is set, the counter goes up by one on every clock. While run is clear, the counter holds its value.
- R4: The raw counter at offset 0x08 is 31 bits wide. A write loads it on the next clock and takes priority over counting. A read returns it with bit 31 at zero. The counter wraps from 0x7FFFFFFF to 0.
- R5: Offset 0x10 reads the scaled count, counter[scale+15:scale], zero-extended to 32 bits.
- R6: Output i is low while the scaled count is less than threshold i and high otherwise.
- R7: A threshold of 0 keeps its output high at every count. A threshold of 0xFFFF drives the output low at scaled count 0xFFFE and high at scaled count 0xFFFF, so the output is never low for a whole period.
- R8: With restart (bit 9) clear, the scaled count wraps from 0xFFFF to 0. With restart set and run set, the counter becomes 0 on the clock after the scaled count equals threshold 0.
- R9: A threshold write changes its output from the first cycle after the write, even in the middle of a period.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the register accessed |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, same cycle |
| pwmOutN | output | 4 | Active-low PWM outputs, one per channel |

## Verification
The comparators are tested by placing the stopped counter just below, at and above a threshold. This separates a less-than test from a less-or-equal test, and the 0 and 0xFFFF thresholds expose any off-by-one at the ends of the period. The scale window is read at scale 0, 4 and 15, which shows whether the shift picks the correct bits. The running counter is sampled a known number of cycles after run is set and again after it is cleared, and after the all-ones value, so that counting, holding and the wrap at both widths can be told apart. A short run with restart on shows whether channel 0's threshold ends the period. A threshold write in the middle of a period shows whether the output follows at once.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  parameter int SCALE_W = 4;

  localparam int CFG_ZC_BIT  = 9;
  localparam int CFG_RUN_BIT = 12;
  // bits kept by the configuration word: scale, 8, 9, 10, 12, 13, 16, 24, 28
  localparam logic [31:0] CFG_KEEP_MASK = 32'h1101_370F;

  localparam int OFF_CFG      = 'h00;
  localparam int OFF_CNT      = 'h08;
  localparam int OFF_SCALED   = 'h10;
  localparam int OFF_CMP_BASE = 'h20;
  localparam int CMP_STRIDE   = 4;

  typedef struct packed {
    logic               cntLoad;
    logic               run;
    logic               zeroCmp;
    logic [SCALE_W-1:0] scale;
  } dpStrobe_t;
endpackage

// File: rtl/spwm_ctrl.sv
module spwm_ctrl
  import spwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CMP_W  = 16,
  parameter int CNT_W  = 31,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWrEn,
  input  logic [DATA_W-1:0]       busWrData,
  output logic [DATA_W-1:0]       busRdData,
  input  logic [CNT_W-1:0]        cntVal,
  input  logic [CMP_W-1:0]        scaledVal,
  output dpStrobe_t               strobes,
  output logic [NUM_CH*CMP_W-1:0] cmpFlat
);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_CNT    = ADDR_W'(OFF_CNT);
  localparam logic [ADDR_W-1:0] A_SCALED = ADDR_W'(OFF_SCALED);

  logic [DATA_W-1:0] cfgReg;
  logic [CMP_W-1:0]  cmpReg [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (busWrEn && busAddr == A_CFG) begin
      cfgReg <= busWrData & DATA_W'(CFG_KEEP_MASK);
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(OFF_CMP_BASE + CMP_STRIDE * i);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpReg[i] <= '0;
      end else if (busWrEn && busAddr == A_CMP) begin
        cmpReg[i] <= busWrData[CMP_W-1:0];
      end
    end
    assign cmpFlat[i*CMP_W +: CMP_W] = cmpReg[i];
  end

  always_comb begin
    busRdData = '0;
    if (busAddr == A_CFG)    busRdData = cfgReg;
    if (busAddr == A_CNT)    busRdData = DATA_W'(cntVal);
    if (busAddr == A_SCALED) busRdData = DATA_W'(scaledVal);
    for (int i = 0; i < NUM_CH; i++) begin
      if (busAddr == ADDR_W'(OFF_CMP_BASE + CMP_STRIDE * i)) begin
        busRdData = DATA_W'(cmpReg[i]);
      end
    end
  end

  always_comb begin
    strobes.cntLoad = busWrEn && (busAddr == A_CNT);
    strobes.run     = cfgReg[CFG_RUN_BIT];
    strobes.zeroCmp = cfgReg[CFG_ZC_BIT];
    strobes.scale   = cfgReg[SCALE_W-1:0];
  end
endmodule

// File: rtl/spwm_datapath.sv
module spwm_datapath
  import spwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CMP_W  = 16,
  parameter int CNT_W  = 31
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobes,
  input  logic [CNT_W-1:0]        loadVal,
  input  logic [NUM_CH*CMP_W-1:0] cmpFlat,
  output logic [CNT_W-1:0]        cntVal,
  output logic [CMP_W-1:0]        scaledVal,
  output logic [NUM_CH-1:0]       pwmOutN
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] shifted;
  logic             restartHit;

  // window counter[scale+CMP_W-1:scale]
  assign shifted    = cntVal >> strobes.scale;
  assign scaledVal  = shifted[CMP_W-1:0];
  assign restartHit = strobes.zeroCmp && (scaledVal == cmpFlat[CMP_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strobes.cntLoad) begin
      cntVal <= loadVal;
    end else if (strobes.run) begin
      cntVal <= restartHit ? '0 : cntVal + CNT_ONE;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    // low while the scaled count is under the threshold
    assign pwmOutN[i] = !(scaledVal < cmpFlat[i*CMP_W +: CMP_W]);
  end
endmodule

// File: rtl/scaled_pwm_top.sv
module scaled_pwm_top
  import spwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CMP_W  = 16,
  parameter int CNT_W  = 31,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] pwmOutN
);
  dpStrobe_t               strobes;
  logic [CNT_W-1:0]        cntVal;
  logic [CMP_W-1:0]        scaledVal;
  logic [NUM_CH*CMP_W-1:0] cmpFlat;

  spwm_ctrl #(
    .NUM_CH(NUM_CH), .CMP_W(CMP_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .cntVal(cntVal),
    .scaledVal(scaledVal), .strobes(strobes), .cmpFlat(cmpFlat)
  );

  spwm_datapath #(
    .NUM_CH(NUM_CH), .CMP_W(CMP_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadVal(busWrData[CNT_W-1:0]),
    .cmpFlat(cmpFlat), .cntVal(cntVal), .scaledVal(scaledVal), .pwmOutN(pwmOutN)
  );
endmodule

// File: rtl/spwm_checker.sv
module spwm_checker
  import spwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CMP_W  = 16,
  parameter int CNT_W  = 31,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdData,
  input logic [CNT_W-1:0]  loadVal,
  input logic [NUM_CH-1:0] pwmOutN,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CMP_W-1:0]  scaledVal,
  input logic [CMP_W-1:0]  cmp0,
  input dpStrobe_t         strobes
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic mapped;

  always_comb begin
    mapped = (busAddr == ADDR_W'(OFF_CFG)) || (busAddr == ADDR_W'(OFF_CNT)) ||
             (busAddr == ADDR_W'(OFF_SCALED));
    for (int i = 0; i < NUM_CH; i++) begin
      if (busAddr == ADDR_W'(OFF_CMP_BASE + CMP_STRIDE * i)) mapped = 1'b1;
    end
  end

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.run && !strobes.cntLoad) |=> $stable(cntVal)); // R3

  AST_STEP_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && !strobes.cntLoad && !(strobes.zeroCmp && scaledVal == cmp0))
      |=> cntVal == $past(cntVal) + ONE); // R3

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntLoad |=> cntVal == $past(loadVal)); // R4

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && strobes.zeroCmp && !strobes.cntLoad && scaledVal == cmp0)
      |=> cntVal == '0); // R8

  AST_NO_FULL_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (scaledVal == {CMP_W{1'b1}}) |-> (pwmOutN == {NUM_CH{1'b1}})); // R7

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> busRdData == '0); // R10
endmodule

bind scaled_pwm_top spwm_checker #(
  .NUM_CH(NUM_CH), .CMP_W(CMP_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdData(busRdData),
  .loadVal(busWrData[CNT_W-1:0]), .pwmOutN(pwmOutN), .cntVal(cntVal),
  .scaledVal(scaledVal), .cmp0(cmpFlat[CMP_W-1:0]), .strobes(strobes)
);

// File: tb/tb_scaled_pwm_top.sv
module tb_scaled_pwm_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [3:0]  pwmOutN;

  typedef struct {
    bit          isOut;
    logic [31:0] exp;
    string       tag;
  } sbItem_t;

  sbItem_t sbQ[$];
  int pushed = 0, popped = 0, checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scaled_pwm_top dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pwmOutN(pwmOutN)
  );

  // monitor: pops expected items and compares against the live outputs
  initial begin
    forever begin
      sbItem_t it;
      logic [31:0] act;
      wait (pushed != popped);
      #1;
      it = sbQ.pop_front();
      act = it.isOut ? {28'b0, pwmOutN} : busRdData;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
      popped++;
    end
  end

  task automatic expectRd(input logic [7:0] a, input logic [31:0] e, input string tag);
    sbItem_t it;
    busAddr = a;
    it.isOut = 0; it.exp = e; it.tag = tag;
    sbQ.push_back(it);
    pushed++;
    wait (popped == pushed);
  endtask

  task automatic expectOut(input logic [3:0] e, input string tag);
    sbItem_t it;
    it.isOut = 1; it.exp = {28'b0, e}; it.tag = tag;
    sbQ.push_back(it);
    pushed++;
    wait (popped == pushed);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expectRd(8'h00, 32'h0, "R1 cfg");
    expectRd(8'h08, 32'h0, "R1 counter");
    expectRd(8'h10, 32'h0, "R1 scaled");
    for (int i = 0; i < 4; i++) expectRd(8'h20 + 8'(4*i), 32'h0, "R1 threshold");
    expectOut(4'hF, "R1 outputs high");

    // R2 configuration masking and threshold width
    busWrite(8'h00, 32'hFFFF_EFFF);
    expectRd(8'h00, 32'h1101_270F, "R2 cfg mask");
    busWrite(8'h20, 32'hABCD_1234);
    expectRd(8'h20, 32'h0000_1234, "R2 threshold 16 bits");
    busWrite(8'h00, 32'h0);

    // R10 unmapped offsets
    expectRd(8'h04, 32'h0, "R10 read 0x04");
    expectRd(8'h30, 32'h0, "R10 read 0x30");
    expectRd(8'hFC, 32'h0, "R10 read 0xFC");
    busWrite(8'h0C, 32'hFFFF_FFFF);
    expectRd(8'h00, 32'h0, "R10 cfg untouched");
    expectRd(8'h20, 32'h1234, "R10 threshold untouched");
    expectRd(8'h08, 32'h0, "R10 counter untouched");

    // R4 counter width
    busWrite(8'h08, 32'hFFFF_FFFF);
    expectRd(8'h08, 32'h7FFF_FFFF, "R4 counter 31 bits");
    expectRd(8'h10, 32'h0000_FFFF, "R5 scale 0 window");

    // R5 scale window
    busWrite(8'h00, 32'h4);
    busWrite(8'h08, 32'h0001_2345);
    expectRd(8'h10, 32'h0000_1234, "R5 scale 4");
    busWrite(8'h00, 32'hF);
    busWrite(8'h08, 32'h7FFF_8000);
    expectRd(8'h10, 32'h0000_FFFF, "R5 scale 15 top");
    busWrite(8'h08, 32'h0000_8000);
    expectRd(8'h10, 32'h0000_0001, "R5 scale 15 low");
    busWrite(8'h00, 32'h0);

    // R6 comparators (threshold0=0x1234, threshold1=0x100)
    busWrite(8'h24, 32'h100);
    busWrite(8'h08, 32'hFF);
    expectOut(4'hC, "R6 below thresholds");
    busWrite(8'h08, 32'h100);
    expectOut(4'hE, "R6 equal threshold1");
    busWrite(8'h08, 32'h1234);
    expectOut(4'hF, "R6 equal threshold0");

    // R7 extremes
    busWrite(8'h20, 32'hFFFF);
    busWrite(8'h08, 32'hFFFE);
    expectOut(4'hE, "R7 0xFFFF low at 0xFFFE");
    busWrite(8'h08, 32'hFFFF);
    expectOut(4'hF, "R7 0xFFFF high at 0xFFFF");
    busWrite(8'h24, 32'h0);
    busWrite(8'h20, 32'h0);
    busWrite(8'h08, 32'h0);
    expectOut(4'hF, "R7 zero threshold at 0");
    busWrite(8'h08, 32'h1234);
    expectOut(4'hF, "R7 zero threshold at 0x1234");

    // R3 run and hold
    busWrite(8'h08, 32'h100);
    busWrite(8'h00, 32'h1000);
    expectRd(8'h08, 32'h100, "R3 start");
    repeat (5) @(negedge clk);
    expectRd(8'h08, 32'h105, "R3 counting");
    busWrite(8'h00, 32'h0);
    expectRd(8'h08, 32'h107, "R3 stop");
    repeat (3) @(negedge clk);
    expectRd(8'h08, 32'h107, "R3 hold");

    // R8 wraps
    busWrite(8'h08, 32'hFFFF);
    busWrite(8'h00, 32'h1000);
    expectRd(8'h08, 32'hFFFF, "R8 before wrap");
    @(negedge clk);
    expectRd(8'h10, 32'h0, "R8 scaled wrap");
    expectRd(8'h08, 32'h1_0000, "R8 raw carries");
    busWrite(8'h00, 32'h0);
    busWrite(8'h08, 32'h7FFF_FFFF);
    busWrite(8'h00, 32'h1000);
    @(negedge clk);
    expectRd(8'h08, 32'h0, "R4 counter wrap");
    busWrite(8'h00, 32'h0);

    // R8 restart on threshold 0
    busWrite(8'h20, 32'h3);
    busWrite(8'h08, 32'h0);
    busWrite(8'h00, 32'h1200);
    expectRd(8'h08, 32'h0, "R8 restart start");
    repeat (3) @(negedge clk);
    expectRd(8'h08, 32'h3, "R8 reach threshold0");
    @(negedge clk);
    expectRd(8'h08, 32'h0, "R8 restart to zero");
    @(negedge clk);
    expectRd(8'h08, 32'h1, "R8 after restart");
    busWrite(8'h00, 32'h0);

    // R9 mid-period threshold change
    busWrite(8'h20, 32'h0);
    busWrite(8'h08, 32'h10);
    busWrite(8'h28, 32'h8000);
    busWrite(8'h00, 32'h1000);
    expectOut(4'hB, "R9 before change");
    busWrite(8'h28, 32'h5);
    expectOut(4'hF, "R9 immediate change");
    busWrite(8'h00, 32'h0);

    done = 1;
    finishRun();
  end
endmodule